// File: doc/BRIEF.md
# Half to Single Precision Float Widener

This block takes one IEEE 754 binary16 code per clock and returns the binary32 code that has the same value. It sits on a datapath where half-precision operands must enter single-precision arithmetic. The sign is copied across. Normal numbers get a new exponent bias. Half subnormals become single normal numbers after a leading-one search. Zeros and infinities pass through, and NaNs come out quiet. Every half value fits exactly in single precision, so the block never rounds.

The input side is a 16-bit word qualified by a valid strobe. The result and its valid strobe are registered, and they appear one clock after the input is sampled. The result register keeps its value while no valid input arrives. A synchronous reset clears both the result and its valid.

Top module: `h2s_widen`

## Requirements
- R1: While `rst` is high at a clock edge, `outValid` and `outWord` are both cleared to zero at that edge.
- R2: `outValid` equals the `inValid` sampled at the previous rising edge.
- R3: An input whose bits [14:0] are all zero gives `outWord = {inWord[15], 31'b0}`, a zero with the same sign.
- R4: An input with exponent field [14:10] = 5'h1F and mantissa [9:0] = 0 gives an infinity: output bits [30:23] = 8'hFF and bits [22:0] = 0.
- R5: An input with exponent field 5'h1F and a non-zero mantissa gives a quiet NaN: output bits [30:23] = 8'hFF, bit 22 = 1, and bits [21:13] = input mantissa bits [8:0], with bits [12:0] = 0.
- R6: An input with an exponent field from 1 to 30 gives output exponent bits [30:23] = half exponent + 112, and output mantissa bits [22:13] = input bits [9:0] with bits [12:0] = 0.
- R7: A subnormal input (exponent 0, mantissa m ≠ 0) gives a normal output. Let z be the number of zeros above the highest set bit of the 10-bit m. The output exponent is 112 − z, and the output mantissa is m shifted left by z+1 within 10 bits and placed at bits [22:13].
- R8: When `inValid` is low at a rising edge, `outWord` keeps its previous value.
- R9: Output bit 31 always equals bit 15 of the sampled input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Qualifies `inWord` in this cycle |
| inWord | input | 16 | binary16 operand |
| outValid | output | 1 | `outWord` holds a fresh result |
| outWord | output | 32 | binary32 result, registered |

## Verification
The bench builds the block with its default field widths (5/10 in, 8/23 out). Those widths keep the input space at 65536 codes, so every half value can be applied back to back and compared against an independent normalizing model. Directed cases come first and target the class boundaries: the smallest and largest subnormals, the smallest and largest normals, signed zeros, infinities and NaN payloads. The same stimulus also covers holding the result when the input is idle and clearing it on reset.

// File: rtl/h2s_pkg.sv
package h2s_pkg;
  localparam int HALF_EW   = 5;
  localparam int HALF_MW   = 10;
  localparam int SGL_EW    = 8;
  localparam int SGL_MW    = 23;
  localparam int HALF_W    = 1 + HALF_EW + HALF_MW;
  localparam int SGL_W     = 1 + SGL_EW + SGL_MW;
  localparam int HALF_BIAS = (1 << (HALF_EW - 1)) - 1;
  localparam int SGL_BIAS  = (1 << (SGL_EW - 1)) - 1;
  localparam int EXP_ADJ   = SGL_BIAS - HALF_BIAS;
  localparam int MAN_PAD   = SGL_MW - HALF_MW;
  localparam int LZ_W      = $clog2(HALF_MW + 1);

  typedef struct packed {
    logic loadEn;
    logic clearAll;
  } ctrlStrobe_t;

  typedef enum logic [1:0] {
    CLS_ZERO    = 2'd0,
    CLS_SUBNORM = 2'd1,
    CLS_NORMAL  = 2'd2,
    CLS_SPECIAL = 2'd3
  } halfClass_t;
endpackage

// File: rtl/h2s_lzc.sv
module h2s_lzc #(
  parameter int WIDTH = h2s_pkg::HALF_MW,
  localparam int CW = $clog2(WIDTH + 1)
) (
  input  logic [WIDTH-1:0] vecIn,
  output logic [CW-1:0]    zeroCount
);
  // Per-bit candidate counts; the highest set bit wins.
  logic [CW-1:0] candidate [WIDTH];

  genvar g;
  generate
    for (g = 0; g < WIDTH; g++) begin : g_cand
      assign candidate[g] = CW'(WIDTH - 1 - g);
    end
  endgenerate

  always_comb begin
    zeroCount = CW'(WIDTH);
    for (int i = 0; i < WIDTH; i++) begin
      if (vecIn[i]) zeroCount = candidate[i];
    end
  end
endmodule

// File: rtl/h2s_ctrl.sv
module h2s_ctrl (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 inValid,
  output h2s_pkg::ctrlStrobe_t strobes,
  output logic                 outValid
);
  always_comb begin
    strobes.clearAll = rst;
    strobes.loadEn   = inValid & ~rst;
  end

  always_ff @(posedge clk) begin
    if (rst) outValid <= 1'b0;
    else     outValid <= inValid;
  end
endmodule

// File: rtl/h2s_datapath.sv
module h2s_datapath
  import h2s_pkg::*;
#(
  parameter int HEW = HALF_EW,
  parameter int HMW = HALF_MW,
  parameter int SEW = SGL_EW,
  parameter int SMW = SGL_MW,
  localparam int HW   = 1 + HEW + HMW,
  localparam int SW   = 1 + SEW + SMW,
  localparam int PAD  = SMW - HMW,
  localparam int ADJ  = ((1 << (SEW - 1)) - 1) - ((1 << (HEW - 1)) - 1),
  localparam int CW   = $clog2(HMW + 1)
) (
  input  logic          clk,
  input  ctrlStrobe_t   strobes,
  input  logic [HW-1:0] inWord,
  output logic [SW-1:0] outWord
);
  logic           sgn;
  logic [HEW-1:0] hExp;
  logic [HMW-1:0] hMan;
  logic [CW-1:0]  lzCount;
  logic [HMW-1:0] subMan;
  logic [SEW-1:0] subExp;
  logic [SEW-1:0] normExp;
  logic [SMW-1:0] nanMan;
  halfClass_t     cls;
  logic [SW-1:0]  nextWord;

  assign sgn  = inWord[HW-1];
  assign hExp = inWord[HW-2 -: HEW];
  assign hMan = inWord[HMW-1:0];

  h2s_lzc #(.WIDTH(HMW)) lzc_i (
    .vecIn     (hMan),
    .zeroCount (lzCount)
  );

  always_comb begin
    if (hExp == {HEW{1'b1}})  cls = CLS_SPECIAL;
    else if (hExp != '0)      cls = CLS_NORMAL;
    else if (hMan != '0)      cls = CLS_SUBNORM;
    else                      cls = CLS_ZERO;
  end

  // The leading one shifts out of the top, leaving the fraction.
  assign subMan  = HMW'(hMan << (lzCount + 1'b1));
  assign subExp  = SEW'(ADJ) - SEW'(lzCount);
  assign normExp = SEW'(hExp) + SEW'(ADJ);
  assign nanMan  = {hMan, {PAD{1'b0}}} | {1'b1, {(SMW-1){1'b0}}};

  always_comb begin
    unique case (cls)
      CLS_ZERO:    nextWord = {sgn, {(SW-1){1'b0}}};
      CLS_SUBNORM: nextWord = {sgn, subExp, subMan, {PAD{1'b0}}};
      CLS_NORMAL:  nextWord = {sgn, normExp, hMan, {PAD{1'b0}}};
      default: begin
        if (hMan == '0) nextWord = {sgn, {SEW{1'b1}}, {SMW{1'b0}}};
        else            nextWord = {sgn, {SEW{1'b1}}, nanMan};
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (strobes.clearAll)    outWord <= '0;
    else if (strobes.loadEn) outWord <= nextWord;
  end
endmodule

// File: rtl/h2s_widen.sv
module h2s_widen
  import h2s_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [HALF_W-1:0] inWord,
  output logic              outValid,
  output logic [SGL_W-1:0]  outWord
);
  ctrlStrobe_t strobes;

  h2s_ctrl ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .strobes  (strobes),
    .outValid (outValid)
  );

  h2s_datapath dp_i (
    .clk     (clk),
    .strobes (strobes),
    .inWord  (inWord),
    .outWord (outWord)
  );
endmodule

// File: rtl/h2s_widen_chk.sv
module h2s_widen_chk
  import h2s_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              inValid,
  input logic [HALF_W-1:0] inWord,
  input logic              outValid,
  input logic [SGL_W-1:0]  outWord
);
  // R2
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);
  a_r2_idle_follows: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid);
  // R8
  a_r8_hold_idle: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> $stable(outWord));
  // R3
  a_r3_zero: assert property (@(posedge clk) disable iff (rst)
    (inValid && inWord[HALF_W-2:0] == '0) |=> outWord[SGL_W-2:0] == '0);
  // R4
  a_r4_inf: assert property (@(posedge clk) disable iff (rst)
    (inValid && inWord[HALF_W-2:0] == 15'h7C00) |=> outWord[SGL_W-2:0] == 31'h7F80_0000);
  // R5
  a_r5_nan_quiet: assert property (@(posedge clk) disable iff (rst)
    (inValid && inWord[14:10] == 5'h1F && inWord[9:0] != '0) |=> outWord[30:22] == 9'h1FF);
  // R9
  a_r9_sign: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outWord[SGL_W-1] == $past(inWord[HALF_W-1]));
endmodule

bind h2s_widen h2s_widen_chk chk_i (.*);

// File: tb/h2s_widen_tb.sv
`timescale 1ns/1ps
module h2s_widen_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic [15:0] inWord = '0;
  logic        outValid;
  logic [31:0] outWord;
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  h2s_widen dut_i (
    .clk(clk), .rst(rst), .inValid(inValid), .inWord(inWord),
    .outValid(outValid), .outWord(outWord)
  );

  function automatic logic [31:0] refConv(input logic [15:0] h);
    logic        s;
    logic [4:0]  e;
    logic [10:0] mm;
    int          ex;
    s = h[15]; e = h[14:10]; mm = {1'b0, h[9:0]};
    if (e == 5'h1F) begin
      if (mm == 0) return {s, 8'hFF, 23'h0};
      return {s, 8'hFF, 1'b1, mm[8:0], 13'h0};
    end
    if (e == 0 && mm == 0) return {s, 31'h0};
    if (e == 0) begin
      ex = 113;
      while (mm[10] == 1'b0) begin mm = mm << 1; ex = ex - 1; end
      return {s, 8'(ex), mm[9:0], 13'h0};
    end
    return {s, 8'(int'(e) + 112), mm[9:0], 13'h0};
  endfunction

  function automatic string tagOf(input logic [15:0] h);
    if (h[14:0] == 0) return "R3";
    if (h[14:10] == 5'h1F) return (h[9:0] == 0) ? "R4" : "R5";
    if (h[14:10] == 0) return "R7";
    return "R6";
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive one cycle, return after the edge has updated outputs
  task automatic step(input logic v, input logic [15:0] w);
    inValid = v; inWord = w;
    @(posedge clk); #1;
  endtask

  task automatic convOne(input logic [15:0] w);
    step(1'b1, w);
    check(tagOf(w), outWord, refConv(w));
    check("R9", {31'h0, outWord[31]}, {31'h0, w[15]});
  endtask

  task automatic t_reset;
    step(1'b1, 16'h3C00);
    check("R1", {31'h0, outValid}, 32'h0);
    check("R1", outWord, 32'h0);
    rst = 1'b0;
  endtask

  task automatic t_latency;
    step(1'b1, 16'h4000);
    check("R2", {31'h0, outValid}, 32'h1);
    step(1'b0, 16'h4000);
    check("R2", {31'h0, outValid}, 32'h0);
  endtask

  task automatic t_zero;
    convOne(16'h0000); convOne(16'h8000);
  endtask

  task automatic t_special;
    convOne(16'h7C00); convOne(16'hFC00);   // R4
    convOne(16'h7C01); convOne(16'hFE00);   // R5
    convOne(16'h7DFF); convOne(16'hFFFF);   // R5
  endtask

  task automatic t_normal;
    convOne(16'h0400); convOne(16'h3C00);   // R6
    convOne(16'h7BFF); convOne(16'hC555);   // R6
  endtask

  task automatic t_subnormal;
    convOne(16'h0001); convOne(16'h03FF);   // R7
    convOne(16'h0200); convOne(16'h8155);   // R7
  endtask

  task automatic t_hold;
    convOne(16'h4248);
    step(1'b0, 16'h1234);
    check("R8", outWord, refConv(16'h4248));
    step(1'b0, 16'hFC00);
    check("R8", outWord, refConv(16'h4248));
  endtask

  task automatic t_reset_mid;
    convOne(16'h5555);
    rst = 1'b1;
    step(1'b1, 16'h1111);
    check("R1", outWord, 32'h0);
    check("R1", {31'h0, outValid}, 32'h0);
    rst = 1'b0;
  endtask

  task automatic t_sweep;
    for (int i = 0; i < 65536; i++) begin
      step(1'b1, 16'(i));
      check(tagOf(16'(i)), outWord, refConv(16'(i)));
    end
  endtask

  initial begin
    #1;
    t_reset();
    t_latency();
    t_zero();
    t_special();
    t_normal();
    t_subnormal();
    t_hold();
    t_reset_mid();
    t_sweep();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule